// File: doc/BRIEF.md
# Gated-Tick Reloading Timer with Overflow-Framed PWM

This block is a free-running up-counter with automatic reload. Its count tick comes from a slow source that only passes while a second, enable-level source is high. Each rising edge of that gated signal is detected in the system clock domain and advances the count by one. The preset is written through `preset_we`, and the same write also loads the counter. When the counter is at its all-ones value and the next tick arrives, it reloads the preset and emits a one-cycle overflow strobe. Other logic can use that strobe, for example to start a conversion or to latch a converter.

Each overflow sets a sticky interrupt flag and advances a small frame counter. A pulse-width output is derived from the frame counter. A frame is 2^FRAME_W overflow periods long, 16 with the defaults. The output is high for a number of those periods equal to a duty field that is written through the control port. All register accesses are plain single-cycle write strobes with data. No interface carries a data stream, so there is no handshake and no back-pressure.

Top module: `gated_reload_timer`

## Requirements
- R1: A cycle with `preset_we` high stores `preset_wdata` as the reload value, and `count` shows it after the next clock edge. If a tick is due in that same cycle, the write wins and the tick is dropped.
- R2: While `src_a` is 1, each rising edge of `src_b` increments `count` by one. The new count is visible three clock edges after the edge is presented: two synchronizer stages, then the counter register.
- R3: While `src_a` is 0, edges on `src_b` leave `count` unchanged.
- R4: A tick that arrives while `count` is 0xFFFF (all ones) reloads the stored preset and raises `ovf_strobe` for exactly one cycle. No other tick raises `ovf_strobe`.
- R5: `irq` is set in the cycle after `ovf_strobe` and then stays high. A cycle with `clr_we` high and `clr_wdata`=1 clears it. A cycle with `clr_wdata`=0 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R6: The duty value is bits [9:6] of `ctrl_wdata`, taken on `ctrl_we`. Over any 16 consecutive overflow periods, `pwm_out` is high in exactly duty of them. The frame counter advances one cycle after each `ovf_strobe`.
- R7: With a duty of 0, `pwm_out` stays low. With a duty of 15, it is high for 15 of every 16 overflow periods.
- R8: After reset, `count` is 0, the preset is 0, and `irq`, `ovf_strobe` and `pwm_out` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 1 | Enable level; ticks pass only while it is high |
| src_b | input | 1 | Slow tick source |
| preset_we | input | 1 | Writes the preset and loads the counter |
| preset_wdata | input | CNT_W | Preset value |
| ctrl_we | input | 1 | Writes the control word |
| ctrl_wdata | input | CTRL_W | Control word; duty is in bits [9:6] |
| clr_we | input | 1 | Write strobe for the interrupt clear |
| clr_wdata | input | 1 | A 1 clears `irq` |
| count | output | CNT_W | Current count |
| irq | output | 1 | Sticky overflow interrupt flag |
| ovf_strobe | output | 1 | One-cycle overflow pulse |
| pwm_out | output | 1 | Overflow-framed pulse-width output |

## Verification
Two pairs of functions can land on the same clock edge. First, a preset write can coincide with a pending tick. The bench provokes this by asserting `preset_we` in the cycle in which the detected tick is due. It then checks that `count` equals the written value, not that value plus one, and that no overflow was taken. Second, an interrupt clear can coincide with a set. The bench raises `clr_we` in exactly the cycle that `ovf_strobe` is high and expects `irq` to read 1 afterwards. A clear issued in a quiet cycle is checked to bring `irq` to 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DEF_CNT_W    = 16;
  localparam int DEF_FRAME_W  = 4;
  localparam int DEF_CTRL_W   = 16;
  localparam int DEF_DUTY_LSB = 6;
  localparam int DEF_SYNC     = 2;

  function automatic logic all_ones(input logic [63:0] v, input int w);
    logic r;
    r = 1'b1;
    for (int i = 0; i < 64; i++)
      if (i < w && !v[i]) r = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/tmr_tick_gate.sv
module tmr_tick_gate #(
  parameter int SYNC_STAGES = tmr_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_a,
  input  logic src_b,
  output logic tick
);
  logic gated;
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;

  assign gated = src_a & src_b;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= gated;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], gated};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign tick = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/tmr_reload_cnt.sv
module tmr_reload_cnt #(
  parameter int CNT_W = tmr_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic             at_top;

  assign at_top = tmr_pkg::all_ones(64'(cnt_q), CNT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preset_q <= '0;
      cnt_q    <= '0;
      wrap_q   <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (load_we) begin
        preset_q <= load_val;
        cnt_q    <= load_val;
      end else if (tick) begin
        if (at_top) begin
          cnt_q  <= preset_q;
          wrap_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign count = cnt_q;
  assign wrap  = wrap_q;
endmodule

// File: rtl/tmr_pwm_frame.sv
module tmr_pwm_frame #(
  parameter int FRAME_W = tmr_pkg::DEF_FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic               duty_we,
  input  logic [FRAME_W-1:0] duty_val,
  output logic [FRAME_W-1:0] duty,
  output logic               pwm
);
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      duty_q  <= '0;
    end else begin
      if (step)    frame_q <= frame_q + FRAME_W'(1);
      if (duty_we) duty_q  <= duty_val;
    end
  end

  assign duty = duty_q;
  assign pwm  = frame_q < duty_q;
endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer #(
  parameter int CNT_W       = tmr_pkg::DEF_CNT_W,
  parameter int FRAME_W     = tmr_pkg::DEF_FRAME_W,
  parameter int CTRL_W      = tmr_pkg::DEF_CTRL_W,
  parameter int DUTY_LSB    = tmr_pkg::DEF_DUTY_LSB,
  parameter int SYNC_STAGES = tmr_pkg::DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_a,
  input  logic              src_b,
  input  logic              preset_we,
  input  logic [CNT_W-1:0]  preset_wdata,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              clr_we,
  input  logic              clr_wdata,
  output logic [CNT_W-1:0]  count,
  output logic              irq,
  output logic              ovf_strobe,
  output logic              pwm_out
);
  localparam int DUTY_MSB = DUTY_LSB + FRAME_W - 1;

  logic               tick;
  logic               wrap;
  logic [FRAME_W-1:0] duty_w;
  logic               irq_q;

  tmr_tick_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b), .tick(tick)
  );

  tmr_reload_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_we(preset_we),
    .load_val(preset_wdata), .count(count), .wrap(wrap)
  );

  tmr_pwm_frame #(.FRAME_W(FRAME_W)) u_pwm (
    .clk(clk), .rst_n(rst_n), .step(wrap), .duty_we(ctrl_we),
    .duty_val(ctrl_wdata[DUTY_MSB:DUTY_LSB]), .duty(duty_w), .pwm(pwm_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                     irq_q <= 1'b0;
    else if (wrap)                  irq_q <= 1'b1;
    else if (clr_we && clr_wdata)   irq_q <= 1'b0;
  end

  assign irq        = irq_q;
  assign ovf_strobe = wrap;
endmodule

// File: rtl/gated_reload_timer_chk.sv
module gated_reload_timer_chk #(
  parameter int CNT_W   = 16,
  parameter int FRAME_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               preset_we,
  input logic               ctrl_we,
  input logic               clr_we,
  input logic               clr_wdata,
  input logic [CNT_W-1:0]   count,
  input logic               irq,
  input logic               ovf_strobe,
  input logic               pwm_out,
  input logic [FRAME_W-1:0] duty
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_we |=> (count == $past(count) || count == $past(count) + CNT_W'(1) || ovf_strobe)); // R2
  AST_WRAP_FROM_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_strobe |-> $past(count) == TOP); // R4
  AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_strobe |=> !ovf_strobe); // R4
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_strobe |=> irq); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(clr_we && clr_wdata)) |=> irq); // R5
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_wdata && !ovf_strobe) |=> !irq); // R5
  AST_PWM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_strobe && !ctrl_we) |=> $stable(pwm_out)); // R6
  AST_PWM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> !pwm_out); // R7
endmodule

bind gated_reload_timer gated_reload_timer_chk #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .preset_we(preset_we), .ctrl_we(ctrl_we),
  .clr_we(clr_we), .clr_wdata(clr_wdata), .count(count), .irq(irq),
  .ovf_strobe(ovf_strobe), .pwm_out(pwm_out), .duty(duty_w)
);

// File: tb/tb_gated_reload_timer.sv
`timescale 1ns/1ps
module tb_gated_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_a = 1'b0, src_b = 1'b0;
  logic        preset_we = 1'b0, ctrl_we = 1'b0, clr_we = 1'b0, clr_wdata = 1'b0;
  logic [15:0] preset_wdata = '0, ctrl_wdata = '0;
  logic [15:0] count;
  logic        irq, ovf_strobe, pwm_out;

  int total = 0, fails = 0, ovf_seen = 0;
  bit done = 0;
  logic [15:0] exp_cnt = '0, exp_pre = '0;

  always #2.5 clk = ~clk;

  gated_reload_timer dut (
    .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
    .preset_we(preset_we), .preset_wdata(preset_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .count(count), .irq(irq), .ovf_strobe(ovf_strobe), .pwm_out(pwm_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ovf_strobe) ovf_seen++;
    end
  endtask

  task automatic tick_once();
    ovf_seen = 0;
    src_b = 1'b1;
    wait_n(3);
    src_b = 1'b0;
    wait_n(3);
    if (src_a) begin
      if (exp_cnt == 16'hFFFF) exp_cnt = exp_pre;
      else exp_cnt = exp_cnt + 16'd1;
    end
  endtask

  task automatic write_preset(input logic [15:0] v);
    @(negedge clk);
    preset_we = 1'b1; preset_wdata = v;
    @(negedge clk);
    preset_we = 1'b0;
    exp_pre = v; exp_cnt = v;
  endtask

  task automatic clear_irq(input logic bitv);
    @(negedge clk);
    clr_we = 1'b1; clr_wdata = bitv;
    @(negedge clk);
    clr_we = 1'b0; clr_wdata = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 count", count, 0);
    chk("R8 irq", irq, 0);
    chk("R8 ovf", ovf_strobe, 0);
    chk("R8 pwm", pwm_out, 0);

    // R2 latency: edge presented, count changes only after the third edge
    src_a = 1'b1;
    write_preset(16'h0010);
    chk("R1 load", count, 16'h0010);
    src_b = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R2 no early step", count, 16'h0010);
    @(negedge clk);
    chk("R2 step after three edges", count, 16'h0011);
    src_b = 1'b0; wait_n(3);
    exp_cnt = 16'h0011;

    // R3 gating
    src_a = 1'b0;
    for (int i = 0; i < 3; i++) tick_once();
    chk("R3 halted", count, exp_cnt);
    src_a = 1'b1;

    // R2/R4 sweep over presets near the top
    for (int p = 0; p < 6; p++) begin
      logic [15:0] pv;
      pv = 16'hFFFF - 16'(p * 3);
      write_preset(pv);
      for (int t = 0; t < 20; t++) begin
        logic wrap_exp;
        wrap_exp = (exp_cnt == 16'hFFFF);
        tick_once();
        chk("R2 R4 count", count, exp_cnt);
        chk("R4 ovf pulses", ovf_seen, wrap_exp ? 1 : 0);
      end
    end

    // R5 sticky, no-op clear, clear
    chk("R5 sticky set", irq, 1);
    clear_irq(1'b0);
    chk("R5 clr bit zero ignored", irq, 1);
    clear_irq(1'b1);
    chk("R5 cleared", irq, 0);
    tick_once();
    chk("R5 stays clear without overflow", irq, (exp_cnt == exp_pre && ovf_seen == 1) ? 1 : 0);
    clear_irq(1'b1);

    // R5 set and clear in the same cycle: set wins
    write_preset(16'hFFFF);
    src_b = 1'b1;
    wait_n(2);
    @(negedge clk);
    chk("R4 ovf in expected cycle", ovf_strobe, 1);
    clr_we = 1'b1; clr_wdata = 1'b1;
    @(negedge clk);
    clr_we = 1'b0; clr_wdata = 1'b0;
    chk("R5 set wins over clear", irq, 1);
    src_b = 1'b0; wait_n(3);
    clear_irq(1'b1);

    // R1 write coinciding with a due tick: write wins
    write_preset(16'h1000);
    src_b = 1'b1;
    wait_n(2);
    preset_we = 1'b1; preset_wdata = 16'h2345;
    @(negedge clk);
    preset_we = 1'b0;
    src_b = 1'b0; wait_n(3);
    chk("R1 write wins over tick", count, 16'h2345);
    exp_pre = 16'h2345; exp_cnt = 16'h2345;

    // R6/R7 sweep every duty value; every tick overflows
    write_preset(16'hFFFF);
    for (int d = 0; d < 16; d++) begin
      int highs;
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = 16'(d) << 6;
      @(negedge clk);
      ctrl_we = 1'b0;
      highs = 0;
      for (int t = 0; t < 16; t++) begin
        if (pwm_out) highs++;
        tick_once();
      end
      chk((d == 0 || d == 15) ? "R7 duty edge" : "R6 duty", highs, d);
    end
    // R6: ctrl bits outside [9:6] do not touch duty
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = 16'hFC3F;
    @(negedge clk);
    ctrl_we = 1'b0;
    for (int t = 0; t < 16; t++) begin
      chk("R7 zero duty stays low", pwm_out, 0);
      tick_once();
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule